// File: doc/BRIEF.md
# Control Port Region-Aware Write Decoder

This block sits behind a byte-wide serial control port and converts a framed byte stream into word writes aimed at four internal targets: a parameter memory, a program memory, a bank of 16-bit registers and a bank of 8-bit registers. A frame is open while `frame_i` is high. The first byte selects the device and the direction. The next two bytes give a 12-bit start address. All bytes after that are data.

The number of bytes that make up one data word depends on the region that holds the current address. When a word is complete, the block raises a one-cycle write strobe. The strobe carries the region code, the address and the data, zero-extended to 40 bits. The address then steps by one. A burst therefore continues from word to word with no new header, and it can cross from one region into the next. When that happens, the word length changes in the middle of the frame.

Region bounds, the device address and the last writable address are parameters. The default map is:

- parameter memory at 0x000–0x3FF
- program memory at 0x400–0x7FF
- 16-bit registers at 0x800–0x80F
- 8-bit registers at 0x810–0x81F

Top module: `ctlport_write_decoder`

## Requirements
- R1: The first accepted byte of a frame opens the frame only if bits [7:1] equal the device address (default 7'h34) and bit 0 is 0 (write). Any other first byte makes the rest of the frame produce no strobe.
- R2: The second byte gives address bits [11:8] from its bits [3:0], and its bits [7:4] are ignored. The third byte gives address bits [7:0].
- R3: Data bytes arrive most significant first, and the word length follows the current region. Parameter memory takes 4 bytes and keeps 28 bits, so the upper nibble of the first byte is dropped. Program memory takes 5 bytes (40 bits). The 16-bit registers take 2 bytes and the 8-bit registers take 1 byte. Output data is zero-extended to 40 bits.
- R4: `wr_stb_o` is high for exactly the cycle after the clock edge that accepts a word's last byte. In that cycle, `wr_region_o` holds the code of the word's region (0 parameter, 1 program, 2 16-bit registers, 3 8-bit registers) and `wr_addr_o` holds its address. After reset all outputs are 0.
- R5: In a burst, each further word is written to the previous address plus one, with no new address bytes.
- R6: When a burst steps across a region boundary, the next word uses the byte count of the new region.
- R7: If `frame_i` falls before a word is complete, that word is dropped and no strobe is raised. The next frame starts again with a device byte.
- R8: A word written at the last address (default 0x81F) is the final write of the frame. The following words are consumed with that region's byte count and produce no strobe.
- R9: If a word would start at an address that lies in no region, no strobe is raised for the rest of the frame.
- R10: A byte counts only when `byte_valid_i` and `frame_i` are both high. Bytes offered with either signal low change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_i | input | 1 | High while a control transaction is open |
| byte_valid_i | input | 1 | Qualifies `byte_i` for this cycle |
| byte_i | input | 8 | Incoming control byte |
| wr_stb_o | output | 1 | One-cycle write strobe |
| wr_region_o | output | 2 | Region code of the write |
| wr_addr_o | output | 12 | Target address of the write |
| wr_data_o | output | 40 | Zero-extended write data |

## Verification
A wrong byte index or region lookup shows up within one word. The strobe comes early or late relative to the last byte, and the assembled data is misaligned. Every single-word write in the register banks therefore shows such a fault on its first strobe. An address counter that steps wrongly shows on the second strobe of a burst. A missing saturation or a missing frame-abort shows as extra strobes after the boundary word or after a cut frame. A wrong header gate shows as strobes on frames that must stay silent. Every one of these faults is visible within a few cycles of the byte that causes it.

// File: rtl/ctlport_pkg.sv
package ctlport_pkg;

  typedef enum logic [1:0] {
    RGN_PARAM = 2'd0,
    RGN_PROG  = 2'd1,
    RGN_REG16 = 2'd2,
    RGN_REG8  = 2'd3
  } region_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_AHI  = 3'd1,
    ST_ALO  = 3'd2,
    ST_DATA = 3'd3,
    ST_SKIP = 3'd4
  } state_e;

  localparam int unsigned NUM_RGN  = 4;
  localparam int unsigned WORD_W   = 40;
  localparam int unsigned CNT_W    = 3;

  function automatic logic [CNT_W-1:0] rgn_bytes(input region_e r);
    case (r)
      RGN_PARAM: rgn_bytes = 3'd4;
      RGN_PROG:  rgn_bytes = 3'd5;
      RGN_REG16: rgn_bytes = 3'd2;
      default:   rgn_bytes = 3'd1;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] rgn_mask(input region_e r);
    case (r)
      RGN_PARAM: rgn_mask = {{(WORD_W-28){1'b0}}, {28{1'b1}}};
      RGN_PROG:  rgn_mask = {WORD_W{1'b1}};
      RGN_REG16: rgn_mask = {{(WORD_W-16){1'b0}}, {16{1'b1}}};
      default:   rgn_mask = {{(WORD_W-8){1'b0}}, {8{1'b1}}};
    endcase
  endfunction

endpackage

// File: rtl/ctlport_region_map.sv
module ctlport_region_map
  import ctlport_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] PARAM_LO = 12'h000,
  parameter logic [ADDR_W-1:0] PARAM_HI = 12'h3FF,
  parameter logic [ADDR_W-1:0] PROG_LO  = 12'h400,
  parameter logic [ADDR_W-1:0] PROG_HI  = 12'h7FF,
  parameter logic [ADDR_W-1:0] REG16_LO = 12'h800,
  parameter logic [ADDR_W-1:0] REG16_HI = 12'h80F,
  parameter logic [ADDR_W-1:0] REG8_LO  = 12'h810,
  parameter logic [ADDR_W-1:0] REG8_HI  = 12'h81F
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output region_e           region_o,
  output logic [CNT_W-1:0]  nbytes_o
);

  localparam logic [ADDR_W-1:0] LO_TAB [NUM_RGN] = '{PARAM_LO, PROG_LO, REG16_LO, REG8_LO};
  localparam logic [ADDR_W-1:0] HI_TAB [NUM_RGN] = '{PARAM_HI, PROG_HI, REG16_HI, REG8_HI};

  logic [NUM_RGN-1:0] hit_vec;

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_cmp
    assign hit_vec[g] = (addr_i >= LO_TAB[g]) && (addr_i <= HI_TAB[g]);
  end

  always_comb begin
    region_o = RGN_PARAM;
    for (int i = NUM_RGN - 1; i >= 0; i--) begin
      if (hit_vec[i]) region_o = region_e'(i);
    end
  end

  assign hit_o    = |hit_vec;
  assign nbytes_o = rgn_bytes(region_o);

endmodule

// File: rtl/ctlport_word_packer.sv
module ctlport_word_packer
  import ctlport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              first_i,
  input  logic [7:0]        byte_i,
  input  region_e           region_i,
  output logic [WORD_W-1:0] word_o
);

  logic [WORD_W-1:0] sh_q;
  logic [WORD_W-1:0] sh_d;

  always_comb begin
    if (first_i) sh_d = {{(WORD_W-8){1'b0}}, byte_i};
    else         sh_d = {sh_q[WORD_W-9:0], byte_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sh_q <= '0;
    else if (load_i) sh_q <= sh_d;
  end

  assign word_o = sh_d & rgn_mask(region_i);

endmodule

// File: rtl/ctlport_write_decoder.sv
module ctlport_write_decoder
  import ctlport_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter logic [6:0]  DEV_ADDR = 7'h34,
  parameter logic [ADDR_W-1:0] PARAM_LO  = 12'h000,
  parameter logic [ADDR_W-1:0] PARAM_HI  = 12'h3FF,
  parameter logic [ADDR_W-1:0] PROG_LO   = 12'h400,
  parameter logic [ADDR_W-1:0] PROG_HI   = 12'h7FF,
  parameter logic [ADDR_W-1:0] REG16_LO  = 12'h800,
  parameter logic [ADDR_W-1:0] REG16_HI  = 12'h80F,
  parameter logic [ADDR_W-1:0] REG8_LO   = 12'h810,
  parameter logic [ADDR_W-1:0] REG8_HI   = 12'h81F,
  parameter logic [ADDR_W-1:0] LAST_ADDR = REG8_HI
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  output logic              wr_stb_o,
  output logic [1:0]        wr_region_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [WORD_W-1:0] wr_data_o
);

  localparam int unsigned HI_BITS = ADDR_W - 8;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // state
  state_e            state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  idx_q, idx_d;
  logic              sat_q, sat_d;
  logic              stb_q, stb_d;
  logic [1:0]        oreg_q;
  logic [ADDR_W-1:0] oadr_q;
  logic [WORD_W-1:0] odat_q;

  logic              acc;
  logic              hit;
  region_e           region;
  logic [CNT_W-1:0]  nbytes;
  logic              pack_load;
  logic [WORD_W-1:0] word;

  assign acc = frame_i && byte_valid_i;

  ctlport_region_map #(
    .ADDR_W(ADDR_W),
    .PARAM_LO(PARAM_LO), .PARAM_HI(PARAM_HI),
    .PROG_LO(PROG_LO),   .PROG_HI(PROG_HI),
    .REG16_LO(REG16_LO), .REG16_HI(REG16_HI),
    .REG8_LO(REG8_LO),   .REG8_HI(REG8_HI)
  ) i_map (
    .addr_i  (addr_q),
    .hit_o   (hit),
    .region_o(region),
    .nbytes_o(nbytes)
  );

  assign pack_load = acc && (state_q == ST_DATA);

  ctlport_word_packer i_pack (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load_i  (pack_load),
    .first_i (idx_q == '0),
    .byte_i  (byte_i),
    .region_i(region),
    .word_o  (word)
  );

  // next state
  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    idx_d   = idx_q;
    sat_d   = sat_q;
    stb_d   = 1'b0;
    if (!frame_i) begin
      state_d = ST_IDLE;
      idx_d   = '0;
      sat_d   = 1'b0;
    end else if (acc) begin
      case (state_q)
        ST_IDLE: begin
          if (byte_i[7:1] == DEV_ADDR && !byte_i[0]) state_d = ST_AHI;
          else                                       state_d = ST_SKIP;
        end
        ST_AHI: begin
          addr_d[ADDR_W-1:8] = byte_i[HI_BITS-1:0];
          state_d = ST_ALO;
        end
        ST_ALO: begin
          addr_d[7:0] = byte_i;
          idx_d       = '0;
          state_d     = ST_DATA;
        end
        ST_DATA: begin
          if (idx_q == '0 && !hit) begin
            state_d = ST_SKIP;
          end else if (idx_q == nbytes - 3'd1) begin
            idx_d = '0;
            if (!sat_q) begin
              stb_d = 1'b1;
              if (addr_q == LAST_ADDR) sat_d = 1'b1;
              else                     addr_d = addr_q + 1'b1;
            end
          end else begin
            idx_d = idx_q + 3'd1;
          end
        end
        default: state_d = ST_SKIP;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      idx_q   <= '0;
      sat_q   <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      idx_q   <= idx_d;
      sat_q   <= sat_d;
      stb_q   <= stb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      oreg_q <= '0;
      oadr_q <= '0;
      odat_q <= '0;
    end else if (stb_d) begin
      oreg_q <= region;
      oadr_q <= addr_q;
      odat_q <= word;
    end
  end

  assign wr_stb_o    = stb_q;
  assign wr_region_o = oreg_q;
  assign wr_addr_o   = oadr_q;
  assign wr_data_o   = odat_q;

  // checks
  logic in_bounds;
  always_comb begin
    case (wr_region_o)
      2'd0:    in_bounds = wr_addr_o >= PARAM_LO && wr_addr_o <= PARAM_HI;
      2'd1:    in_bounds = wr_addr_o >= PROG_LO  && wr_addr_o <= PROG_HI;
      2'd2:    in_bounds = wr_addr_o >= REG16_LO && wr_addr_o <= REG16_HI;
      default: in_bounds = wr_addr_o >= REG8_LO  && wr_addr_o <= REG8_HI;
    endcase
  end

  assert_region_bounds_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_stb_o |-> in_bounds);

  assert_silent_skip_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q != ST_DATA) |=> !wr_stb_o);

  assert_reg8_width_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_stb_o && wr_region_o == 2'd3) |-> (wr_data_o[WORD_W-1:8] == '0));

  assert_param_width_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_stb_o && wr_region_o == 2'd0) |-> (wr_data_o[WORD_W-1:28] == '0));

  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_stb_o |-> (sat_q ? (addr_q == wr_addr_o) : (addr_q == wr_addr_o + 1'b1)));

  assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !frame_i |=> (state_q == ST_IDLE && idx_q == '0 && !sat_q));

  assert_saturate_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sat_q |-> (addr_q == LAST_ADDR));

endmodule

// File: tb/test_ctlport_write_decoder.sv
module test_ctlport_write_decoder;

  localparam logic [11:0] LAST = 12'h81F;
  localparam logic [7:0]  DEVW = 8'h68;  // 7'h34, write

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_i;
  logic        byte_valid_i;
  logic [7:0]  byte_i;
  logic        wr_stb_o;
  logic [1:0]  wr_region_o;
  logic [11:0] wr_addr_o;
  logic [39:0] wr_data_o;

  int n_checks = 0;
  int n_errors = 0;
  logic mon_on = 1'b0;

  logic [53:0] got_q [$];
  logic [53:0] exp_q [$];

  always #2.5 clk = ~clk;

  ctlport_write_decoder i_ctlport_write_decoder (
    .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .byte_valid_i(byte_valid_i),
    .byte_i(byte_i), .wr_stb_o(wr_stb_o), .wr_region_o(wr_region_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

  always @(negedge clk)
    if (mon_on && wr_stb_o) got_q.push_back({wr_region_o, wr_addr_o, wr_data_o});

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // region code per requirement R3/R4; 4 = no region
  function automatic int rgn(input logic [11:0] a);
    if (a <= 12'h3FF) return 0;
    if (a <= 12'h7FF) return 1;
    if (a <= 12'h80F) return 2;
    if (a <= 12'h81F) return 3;
    return 4;
  endfunction

  function automatic int blen(input int r);
    case (r)
      0: return 4;
      1: return 5;
      2: return 2;
      default: return 1;
    endcase
  endfunction

  function automatic logic [39:0] bmask(input int r);
    case (r)
      0: return 40'h000FFFFFFF;
      1: return 40'hFFFFFFFFFF;
      2: return 40'h000000FFFF;
      default: return 40'h00000000FF;
    endcase
  endfunction

  function automatic logic [39:0] seed(input logic [11:0] a, input int n);
    logic [39:0] s;
    s = {8'hC3 ^ a[7:0], 20'hE1F0D ^ {a, a[7:0]}, a};
    return s ^ {5{n[7:0]}};
  endfunction

  task automatic put_byte(input logic [7:0] b, input bit gappy);
    @(negedge clk);
    frame_i = 1'b1; byte_valid_i = 1'b1; byte_i = b;
    if (gappy) begin
      @(negedge clk);
      byte_valid_i = 1'b0; byte_i = 8'hFF;
    end
  endtask

  // one frame: header, nwords data words, then 'partial' extra bytes
  task automatic frame(input logic [7:0] b0, input logic [3:0] junk, input logic [11:0] a,
                       input int nwords, input int partial, input bit expect_on,
                       input bit gappy, input string tag);
    logic [11:0] cur;
    bit sat, stop;
    cur = a; sat = 0; stop = 0;
    put_byte(b0, gappy);
    put_byte({junk, a[11:8]}, gappy);
    put_byte(a[7:0], gappy);
    for (int w = 0; w < nwords; w++) begin
      int r, n;
      logic [39:0] s;
      r = rgn(cur);
      if (r == 4) stop = 1;
      n = stop ? 1 : blen(r);
      s = seed(cur, w);
      for (int k = n - 1; k >= 0; k--) put_byte(s[k*8 +: 8], gappy);
      if (!stop && !sat) begin
        if (expect_on) exp_q.push_back({r[1:0], cur, s & bmask(r)});
        if (cur == LAST) sat = 1; else cur = cur + 12'd1;
      end
    end
    for (int p = 0; p < partial; p++) put_byte(8'h5A ^ p[7:0], gappy);
    @(negedge clk);
    byte_valid_i = 1'b0;
    frame_i = 1'b0;
    // R10: valid bytes outside a frame must be ignored
    @(negedge clk); byte_valid_i = 1'b1; byte_i = DEVW;
    @(negedge clk); byte_i = 8'h08;
    @(negedge clk); byte_valid_i = 1'b0;
    @(negedge clk);
    check(got_q.size() == exp_q.size(), {tag, " count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      check(got_q[i] == exp_q[i], tag, got_q[i], exp_q[i]);
    got_q.delete();
    exp_q.delete();
  endtask

  initial begin
    #400000;
    n_errors++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; frame_i = 1'b0; byte_valid_i = 1'b0; byte_i = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({wr_stb_o, wr_region_o, wr_addr_o, wr_data_o} == '0, "R4 reset outputs",
          {wr_stb_o, wr_region_o, wr_addr_o, wr_data_o}, 0);
    mon_on = 1'b1;

    // R2 R3 R4: single writes in every register address and spread RAM addresses
    for (int a = 12'h800; a <= 12'h81F; a++)
      frame(DEVW, a[3:0], a[11:0], 1, 0, 1, 0, "R3 single reg");
    for (int a = 0; a < 12'h800; a += 12'h0F7)
      frame(DEVW, 4'hA, a[11:0], 1, 0, 1, 0, "R2 single ram");
    frame(DEVW, 4'hF, 12'h3FF, 1, 0, 1, 0, "R3 param top");
    frame(DEVW, 4'h0, 12'h7FF, 1, 0, 1, 0, "R3 prog top");

    // R5 bursts inside one region
    frame(DEVW, 4'h0, 12'h100, 6, 0, 1, 0, "R5 param burst");
    frame(DEVW, 4'h0, 12'h804, 7, 0, 1, 0, "R5 reg16 burst");

    // R6 bursts crossing boundaries
    frame(DEVW, 4'h0, 12'h3FE, 4, 0, 1, 0, "R6 param to prog");
    frame(DEVW, 4'h0, 12'h7FE, 4, 0, 1, 0, "R6 prog to reg16");
    frame(DEVW, 4'h0, 12'h80E, 4, 0, 1, 0, "R6 reg16 to reg8");

    // R8 saturation at the last address
    frame(DEVW, 4'h0, 12'h81D, 6, 0, 1, 0, "R8 saturate");
    frame(DEVW, 4'h0, 12'h81F, 3, 0, 1, 0, "R8 last only");

    // R1 wrong device addresses and read flag
    for (int d = 0; d < 128; d++)
      if (d != 7'h34) frame({d[6:0], 1'b0}, 4'h0, 12'h810, 2, 0, 0, 0, "R1 wrong device");
    frame({7'h34, 1'b1}, 4'h0, 12'h810, 2, 0, 0, 0, "R1 read flag");

    // R7 frame cut inside a word
    frame(DEVW, 4'h0, 12'h805, 1, 1, 1, 0, "R7 cut reg16");
    frame(DEVW, 4'h0, 12'h200, 2, 3, 1, 0, "R7 cut param");
    frame(DEVW, 4'h0, 12'h600, 0, 4, 1, 0, "R7 cut prog first");
    frame(DEVW, 4'h0, 12'h811, 1, 0, 1, 0, "R7 next frame fresh");

    // R9 start outside every region
    frame(DEVW, 4'h0, 12'h820, 3, 0, 0, 0, "R9 past map");
    frame(DEVW, 4'hF, 12'hFFF, 3, 0, 0, 0, "R9 top address");

    // R10 gaps with invalid bytes inside a frame
    frame(DEVW, 4'h3, 12'h3FD, 3, 0, 1, 1, "R10 gappy burst");
    frame(DEVW, 4'h0, 12'h80F, 2, 0, 1, 1, "R10 gappy regs");

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule